// File: doc/BRIEF.md
# I2S Transmit Frame Serializer

This block is the transmit side of an I2S port running as bus master. It takes one stereo sample pair per frame from a show-ahead FIFO read port. It generates the bit clock from the system clock through a programmable divider and drives the word-select line. It shifts the serial data out MSB first, so that a short sample can sit at any bit offset inside a longer frame.

The sample width, the frame length and the offset of the data inside each channel half are programmed independently. Further settings cover bit-clock and word-select polarity, single-channel output, exchange of the two FIFO halves, and either classic I2S timing (one bit of delay) or left-justified timing. All settings are static while `en` is high. When the FIFO has nothing to offer at a frame start, the frame goes out as zeros and a one-cycle error pulse is raised.

Top module: `i2s_tx_serializer`

## Requirements
- R1: While `en` is low, and after reset, `sck` equals `cfg_sck_pol`, `ws` equals `cfg_ws_pol`, `sd` is 0, and neither `fifo_pop` nor `underrun` is asserted.
- R2: One bit period lasts 2*(`cfg_div_m1`+1) system clocks. The bit clock with polarity removed (`sck` XOR `cfg_sck_pol`) is low for the first half of the period and high for the second half. `sd` changes only where that clock falls, and never while it is high.
- R3: A frame lasts `cfg_frame_len_m1`+1 bit periods and is split into two equal halves. With `cfg_ws_pol`=0, `ws` is low for the left half and high for the right half; `cfg_ws_pol`=1 inverts `ws`.
- R4: With `cfg_left_just`=0, every `ws` transition comes one bit period before the first bit of its half. With `cfg_left_just`=1 it coincides with that first bit, so the last bit of the right half goes out under the following left level in classic mode only.
- R5: Each half carries `cfg_data_len_m1`+1 data bits (4 to 32), MSB first. They start `cfg_position` bits after the first bit of the half. All other bits of the half are 0.
- R6: The FIFO word holds the left sample in bits [31:0] and the right sample in bits [63:32]; a shorter sample is right-aligned in its half. `cfg_swap`=1 exchanges which half feeds which channel.
- R7: With `cfg_mono`=1, the left half carries the sample selected for left and the right half is all zeros.
- R8: At each frame start with `fifo_valid` high, `fifo_pop` is high for exactly one cycle and that word is used for the whole frame. Enabling starts a new frame at once.
- R9: At a frame start with `fifo_valid` low, `fifo_pop` stays low, `underrun` is high for one cycle, and the whole frame is sent as zeros.
- R10: `cfg_sck_pol`=1 inverts the `sck` pin, so data changes on rising pin edges instead of falling ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low holds the block idle |
| cfg_div_m1 | input | DIV_W | Half bit-period length in system clocks, minus one |
| cfg_data_len_m1 | input | 5 | Sample width in bits minus one (3 to 31) |
| cfg_frame_len_m1 | input | 6 | Frame length in bit periods minus one (even frame length) |
| cfg_position | input | 6 | Offset of the data inside each half, in bits |
| cfg_mono | input | 1 | Single-channel output |
| cfg_swap | input | 1 | Exchange the FIFO word halves |
| cfg_left_just | input | 1 | Left-justified timing instead of classic I2S |
| cfg_sck_pol | input | 1 | Bit-clock pin inversion |
| cfg_ws_pol | input | 1 | Word-select pin inversion |
| fifo_valid | input | 1 | FIFO has a word at its head |
| fifo_word | input | 64 | Head word of the FIFO: right sample high, left sample low |
| fifo_pop | output | 1 | Consume the head word this cycle |
| sck | output | 1 | Serial bit clock |
| ws | output | 1 | Word select |
| sd | output | 1 | Serial data |
| underrun | output | 1 | One-cycle pulse when a frame starts with the FIFO empty |

## Verification
The bench builds the block with the package defaults: 32-bit samples at most, 64-bit frames at most and an 8-bit divider. With those limits the bench can reach both extremes of the format. At one end is a full 32-bit sample filling a 64-bit frame, where the classic-mode delay carries the right channel's last bit under the next left level. At the other end is a 4-bit sample in an 8-bit frame. Between them, a sample offset inside a 40-bit frame, swapped and mono layouts under both pin polarities, and divider values of 0 to 3 are compared bit by bit against a scoreboard. The scoreboard also counts pops and underrun pulses.

// File: rtl/i2s_ser_pkg.sv
package i2s_ser_pkg;

    localparam int SER_MAX_DATA  = 32;
    localparam int SER_MAX_FRAME = 64;
    localparam int DLW = $clog2(SER_MAX_DATA);
    localparam int FLW = $clog2(SER_MAX_FRAME);
    localparam int CW  = FLW + 1;

    typedef logic [DLW-1:0]              dlen_t;
    typedef logic [FLW-1:0]              flen_t;
    typedef logic [SER_MAX_DATA-1:0]     sample_t;
    typedef logic [2*SER_MAX_DATA-1:0]   pair_t;

    typedef enum logic {
        SLOT_LEFT  = 1'b0,
        SLOT_RIGHT = 1'b1
    } slot_e;

    typedef struct packed {
        dlen_t data_len_m1;
        flen_t frame_len_m1;
        flen_t position;
        logic  mono;
        logic  swap;
        logic  left_just;
        logic  sck_pol;
        logic  ws_pol;
    } ser_cfg_t;

    typedef struct packed {
        slot_e         slot;
        logic [CW-1:0] offset;
    } slot_pos_t;

    // Number of bit periods in one whole frame.
    function automatic logic [CW-1:0] frame_bits(ser_cfg_t c);
        return {1'b0, c.frame_len_m1} + CW'(1);
    endfunction

    // Bit periods per channel half.
    function automatic logic [CW-1:0] half_bits(ser_cfg_t c);
        return frame_bits(c) >> 1;
    endfunction

    // Map the logical bit index of a frame to its channel and offset.
    function automatic slot_pos_t locate(ser_cfg_t c, flen_t k);
        slot_pos_t     p;
        logic [CW-1:0] h;
        logic [CW-1:0] kk;
        h  = half_bits(c);
        kk = {1'b0, k};
        if (kk >= h) begin
            p.slot   = SLOT_RIGHT;
            p.offset = kk - h;
        end else begin
            p.slot   = SLOT_LEFT;
            p.offset = kk;
        end
        return p;
    endfunction

    // Choose the sample that feeds a channel half.
    function automatic sample_t pick_sample(ser_cfg_t c, pair_t w, slot_e s);
        sample_t lo;
        sample_t hi;
        sample_t r;
        lo = w[SER_MAX_DATA-1:0];
        hi = w[2*SER_MAX_DATA-1:SER_MAX_DATA];
        if (s == SLOT_LEFT) begin
            r = c.swap ? hi : lo;
        end else if (c.mono) begin
            r = '0;
        end else begin
            r = c.swap ? lo : hi;
        end
        return r;
    endfunction

    // Word-select level (before polarity) while logical bit k is on the line.
    // Classic timing leads the data by one bit period.
    function automatic logic ws_level(ser_cfg_t c, flen_t k);
        logic [CW-1:0] b;
        b = {1'b0, k} + (c.left_just ? CW'(0) : CW'(1));
        if (b >= frame_bits(c)) begin
            b = b - frame_bits(c);
        end
        return b >= half_bits(c);
    endfunction

endpackage

// File: rtl/i2s_bit_clock.sv
module i2s_bit_clock
    import i2s_ser_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div_m1,
    output logic             sck_raw,
    output logic             bit_end
);

    logic [DIV_W-1:0] cnt_q;
    logic             phase_q;
    logic             half_end;

    assign half_end = run && (cnt_q == div_m1);
    assign bit_end  = half_end && phase_q;
    assign sck_raw  = phase_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q   <= '0;
            phase_q <= 1'b0;
        end else if (half_end) begin
            cnt_q   <= '0;
            phase_q <= !phase_q;
        end else begin
            cnt_q   <= cnt_q + DIV_W'(1);
        end
    end

endmodule

// File: rtl/i2s_frame_seq.sv
module i2s_frame_seq
    import i2s_ser_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    input  logic  bit_end,
    input  flen_t frame_len_m1,
    input  logic  fifo_valid,
    output logic  running,
    output flen_t kcnt,
    output logic  load,
    output logic  pop,
    output logic  underrun
);

    logic  running_q;
    flen_t kcnt_q;
    logic  frame_end;

    assign frame_end = bit_end && (kcnt_q == frame_len_m1);
    assign load      = en && (!running_q || frame_end);
    assign pop       = load && fifo_valid;
    assign underrun  = load && !fifo_valid;
    assign running   = running_q;
    assign kcnt      = kcnt_q;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            running_q <= 1'b0;
            kcnt_q    <= '0;
        end else begin
            running_q <= 1'b1;
            if (frame_end) begin
                kcnt_q <= '0;
            end else if (bit_end) begin
                kcnt_q <= kcnt_q + FLW'(1);
            end
        end
    end

    // R3: the bit index never leaves the programmed frame
    p_kcnt_in_frame_r3: assert property (@(posedge clk) disable iff (rst)
        running_q |-> (kcnt_q <= frame_len_m1));

endmodule

// File: rtl/i2s_slot_mux.sv
module i2s_slot_mux
    import i2s_ser_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  ser_cfg_t cfg,
    input  logic     running,
    input  flen_t    kcnt,
    input  logic     load,
    input  logic     fifo_valid,
    input  pair_t    fifo_word,
    output logic     sd_bit,
    output logic     ws_raw
);

    pair_t         pair_q;
    slot_pos_t     pos;
    sample_t       smp;
    logic [CW-1:0] rel;
    logic          in_win;
    dlen_t         idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            pair_q <= '0;
        end else if (load) begin
            pair_q <= fifo_valid ? fifo_word : '0;
        end
    end

    always_comb begin
        pos    = locate(cfg, kcnt);
        smp    = pick_sample(cfg, pair_q, pos.slot);
        rel    = pos.offset - {1'b0, cfg.position};
        in_win = (pos.offset >= {1'b0, cfg.position}) &&
                 (rel <= CW'(cfg.data_len_m1));
        idx    = cfg.data_len_m1 - rel[DLW-1:0];
        sd_bit = running && in_win && smp[idx];
        ws_raw = running && ws_level(cfg, kcnt);
    end

endmodule

// File: rtl/i2s_tx_serializer.sv
module i2s_tx_serializer
    import i2s_ser_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      en,
    input  logic [DIV_W-1:0]          cfg_div_m1,
    input  logic [DLW-1:0]            cfg_data_len_m1,
    input  logic [FLW-1:0]            cfg_frame_len_m1,
    input  logic [FLW-1:0]            cfg_position,
    input  logic                      cfg_mono,
    input  logic                      cfg_swap,
    input  logic                      cfg_left_just,
    input  logic                      cfg_sck_pol,
    input  logic                      cfg_ws_pol,
    input  logic                      fifo_valid,
    input  logic [2*SER_MAX_DATA-1:0] fifo_word,
    output logic                      fifo_pop,
    output logic                      sck,
    output logic                      ws,
    output logic                      sd,
    output logic                      underrun
);

    ser_cfg_t cfg;
    logic     running;
    logic     sck_raw;
    logic     bit_end;
    logic     load;
    flen_t    kcnt;
    logic     ws_raw;

    always_comb begin
        cfg.data_len_m1  = cfg_data_len_m1;
        cfg.frame_len_m1 = cfg_frame_len_m1;
        cfg.position     = cfg_position;
        cfg.mono         = cfg_mono;
        cfg.swap         = cfg_swap;
        cfg.left_just    = cfg_left_just;
        cfg.sck_pol      = cfg_sck_pol;
        cfg.ws_pol       = cfg_ws_pol;
    end

    i2s_bit_clock #(.DIV_W(DIV_W)) clk_gen_i (
        .clk     (clk),
        .rst     (rst),
        .run     (running),
        .div_m1  (cfg_div_m1),
        .sck_raw (sck_raw),
        .bit_end (bit_end)
    );

    i2s_frame_seq seq_i (
        .clk          (clk),
        .rst          (rst),
        .en           (en),
        .bit_end      (bit_end),
        .frame_len_m1 (cfg_frame_len_m1),
        .fifo_valid   (fifo_valid),
        .running      (running),
        .kcnt         (kcnt),
        .load         (load),
        .pop          (fifo_pop),
        .underrun     (underrun)
    );

    i2s_slot_mux mux_i (
        .clk        (clk),
        .rst        (rst),
        .cfg        (cfg),
        .running    (running),
        .kcnt       (kcnt),
        .load       (load),
        .fifo_valid (fifo_valid),
        .fifo_word  (fifo_word),
        .sd_bit     (sd),
        .ws_raw     (ws_raw)
    );

    assign sck = sck_raw ^ cfg.sck_pol;
    assign ws  = ws_raw ^ cfg.ws_pol;

    // R2: data holds while the bit clock (polarity removed) is high
    p_sd_hold_high_r2: assert property (@(posedge clk) disable iff (rst)
        (running && $past(running) && sck_raw && $past(sck_raw)) |-> $stable(sd));

    // R3: every falling edge of the bit clock advances the bit index
    p_bit_advance_r3: assert property (@(posedge clk) disable iff (rst)
        (running && $past(running) && $fell(sck_raw)) |-> (kcnt != $past(kcnt)));

    // R8: a consumed word always starts a frame at bit 0
    p_pop_frame_start_r8: assert property (@(posedge clk) disable iff (rst)
        fifo_pop |=> (kcnt == '0));

    // R9: the error flag is a single-cycle pulse
    p_underrun_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        underrun |=> !underrun);

    // R9: no word is consumed while reporting an empty FIFO
    p_underrun_no_pop_r9: assert property (@(posedge clk) disable iff (rst)
        underrun |-> !fifo_pop);

endmodule

// File: tb/i2s_tx_serializer_tb.sv
module i2s_tx_serializer_tb_top;
    import i2s_ser_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic [7:0]  cfg_div_m1 = 8'd1;
    logic [4:0]  cfg_data_len_m1 = 5'd15;
    logic [5:0]  cfg_frame_len_m1 = 6'd31;
    logic [5:0]  cfg_position = 6'd0;
    logic        cfg_mono = 1'b0;
    logic        cfg_swap = 1'b0;
    logic        cfg_left_just = 1'b0;
    logic        cfg_sck_pol = 1'b0;
    logic        cfg_ws_pol = 1'b0;
    logic        fifo_valid = 1'b0;
    logic [63:0] fifo_word = '0;
    logic        fifo_pop, sck, ws, sd, underrun;

    int errors = 0;
    int checks = 0;
    int pops = 0;
    int unders = 0;
    int hold_viol = 0;
    longint cyc = 0;
    bit done = 0;
    string cur_tag = "";
    logic [63:0] fq[$];
    logic [1:0]  exp_q[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    i2s_tx_serializer #(.DIV_W(8)) dut_i (
        .clk(clk), .rst(rst), .en(en), .cfg_div_m1(cfg_div_m1),
        .cfg_data_len_m1(cfg_data_len_m1), .cfg_frame_len_m1(cfg_frame_len_m1),
        .cfg_position(cfg_position), .cfg_mono(cfg_mono), .cfg_swap(cfg_swap),
        .cfg_left_just(cfg_left_just), .cfg_sck_pol(cfg_sck_pol), .cfg_ws_pol(cfg_ws_pol),
        .fifo_valid(fifo_valid), .fifo_word(fifo_word), .fifo_pop(fifo_pop),
        .sck(sck), .ws(ws), .sd(sd), .underrun(underrun)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Expected serial bit from the requirements (R5, R6, R7)
    function automatic bit exp_sd(input int k, input logic [63:0] w);
        int f = int'(cfg_frame_len_m1) + 1;
        int h = f / 2;
        int len = int'(cfg_data_len_m1) + 1;
        int right = (k >= h) ? 1 : 0;
        int off = k - right * h;
        int p = int'(cfg_position);
        logic [31:0] s;
        if (off < p || off >= p + len) return 1'b0;
        if (right == 1 && cfg_mono) return 1'b0;
        s = ((right == 1) != cfg_swap) ? w[63:32] : w[31:0];
        return s[len - 1 - (off - p)];
    endfunction

    // Expected word-select level before polarity (R3, R4)
    function automatic bit exp_ws(input int k);
        int f = int'(cfg_frame_len_m1) + 1;
        int b = (k + (cfg_left_just ? 0 : 1)) % f;
        return b >= f / 2;
    endfunction

    // FIFO model: show-ahead head, removed when popped
    initial begin
        forever begin
            @(negedge clk);
            fifo_valid = (fq.size() > 0);
            fifo_word  = (fq.size() > 0) ? fq[0] : 64'd0;
            #1;
            if (fifo_pop) begin
                pops++;
                if (fq.size() > 0) void'(fq.pop_front());
            end
            if (underrun) unders++;
        end
    end

    // Monitor: compare each bit at the rising edge of the polarity-free clock
    initial begin
        bit prev_raw;
        logic prev_sd;
        bit raw;
        logic [1:0] e;
        prev_raw = 1'b0;
        prev_sd = 1'b0;
        forever begin
            @(negedge clk);
            raw = sck ^ cfg_sck_pol;
            if (raw && prev_raw && (sd !== prev_sd)) hold_viol++;
            if (raw && !prev_raw && exp_q.size() > 0) begin
                e = exp_q.pop_front();
                check({ws ^ cfg_ws_pol, sd} === e, cur_tag, "ws,sd bit",
                      longint'({ws ^ cfg_ws_pol, sd}), longint'(e));
            end
            prev_raw = raw;
            prev_sd = sd;
        end
    end

    task automatic check_idle(input string tag);
        check(sck === cfg_sck_pol, tag, "idle sck", longint'(sck), longint'(cfg_sck_pol));
        check(ws === cfg_ws_pol, tag, "idle ws", longint'(ws), longint'(cfg_ws_pol));
        check(sd === 1'b0, tag, "idle sd", longint'(sd), 0);
        check(fifo_pop === 1'b0 && underrun === 1'b0, tag, "idle pop/underrun",
              longint'({fifo_pop, underrun}), 0);
    endtask

    // Driver: the words already in fq, then nz empty frames
    task automatic run_stream(input string tag, input int nz);
        int nw = fq.size();
        int f = int'(cfg_frame_len_m1) + 1;
        logic [63:0] w;
        cur_tag = tag;
        pops = 0;
        unders = 0;
        hold_viol = 0;
        for (int fr = 0; fr < nw + nz; fr++) begin
            w = (fr < nw) ? fq[fr] : 64'd0;
            for (int k = 0; k < f; k++) exp_q.push_back({exp_ws(k), exp_sd(k, w)});
        end
        @(negedge clk);
        en = 1'b1;
        wait (exp_q.size() == 0);
        @(negedge clk);
        en = 1'b0;
        repeat (3) @(negedge clk);
        check(pops == nw, {tag, " R8"}, "pop count", pops, nw);
        check(unders == nz, {tag, " R9"}, "underrun count", unders, nz);
        check(hold_viol == 0, {tag, " R2"}, "sd moved while clock high", hold_viol, 0);
        check(fq.size() == 0, {tag, " R8"}, "fifo drained", fq.size(), 0);
        check_idle({tag, " R1"});
    endtask

    task automatic measure_period(input logic [7:0] dm1);
        longint t0;
        longint t1;
        cfg_div_m1 = dm1;
        unders = 0;
        @(negedge clk);
        en = 1'b1;
        wait ((sck ^ cfg_sck_pol) == 1'b1);
        t0 = cyc;
        wait ((sck ^ cfg_sck_pol) == 1'b0);
        wait ((sck ^ cfg_sck_pol) == 1'b1);
        t1 = cyc;
        check(t1 - t0 == 2 * (longint'(dm1) + 1), "R2", "bit period in clocks",
              t1 - t0, 2 * (longint'(dm1) + 1));
        check(sd === 1'b0, "R9", "zeros while FIFO empty", longint'(sd), 0);
        @(negedge clk);
        en = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic set_fmt(input int dlen, input int flen, input int posn,
                           input logic [7:0] dm1, input bit mono, input bit swp,
                           input bit lj, input bit spol, input bit wpol);
        cfg_data_len_m1  = 5'(dlen - 1);
        cfg_frame_len_m1 = 6'(flen - 1);
        cfg_position     = 6'(posn);
        cfg_div_m1       = dm1;
        cfg_mono         = mono;
        cfg_swap         = swp;
        cfg_left_just    = lj;
        cfg_sck_pol      = spol;
        cfg_ws_pol       = wpol;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_idle("R1 after reset");

        // Classic 16-in-32, three words then one empty frame
        set_fmt(16, 32, 0, 8'd1, 0, 0, 0, 0, 0);
        fq.push_back(64'h0000_C3A5_0000_9ABC);
        fq.push_back(64'h1234_8001_5678_7FFE);
        fq.push_back(64'hFFFF_0F0F_0000_F00D);
        run_stream("R3/R4/R5/R6", 1);

        // Left-justified, offset 5, 8-bit in 40-bit frame, swapped
        set_fmt(8, 40, 5, 8'd2, 0, 1, 1, 0, 0);
        fq.push_back(64'h0000_00B4_0000_005A);
        fq.push_back(64'hFFFF_FF81_FFFF_FF7E);
        run_stream("R4/R5/R6 swap", 1);

        // Mono 24-bit at offset 3, both polarities inverted
        set_fmt(24, 64, 3, 8'd1, 1, 0, 0, 1, 1);
        @(negedge clk);
        check_idle("R1 R10 inverted idle");
        fq.push_back(64'hAAAA_AAAA_00C3_5A69);
        fq.push_back(64'h5555_5555_0080_0001);
        run_stream("R7/R10", 1);

        // Full 32-bit samples filling a 64-bit frame
        set_fmt(32, 64, 0, 8'd1, 0, 0, 0, 0, 0);
        fq.push_back(64'h8000_0001_F0E1_D2C3);
        fq.push_back(64'h0123_4567_89AB_CDEF);
        run_stream("R4/R5 full frame", 0);

        // Smallest format: 4-bit in an 8-bit frame, back-to-back words
        set_fmt(4, 8, 0, 8'd1, 0, 0, 0, 0, 0);
        fq.push_back(64'h0000_0009_0000_0006);
        fq.push_back(64'h0000_000F_0000_0001);
        fq.push_back(64'h0000_0003_0000_000C);
        run_stream("R5/R8 min format", 2);

        // Bit period for two divider values, FIFO empty
        set_fmt(16, 32, 0, 8'd0, 0, 0, 0, 0, 0);
        measure_period(8'd0);
        measure_period(8'd3);
        check(unders >= 1, "R9", "underrun pulses seen", unders, 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule